// File: doc/BRIEF.md
# Instruction Decoder Address Generator

This block holds the instruction word that the controller has just fetched and turns it into a 7-bit entry address for a microcode lookup ROM. A group decoder sorts the word into one of four classes: special, two-operand, one-operand or zero-operand. The class code forms the upper address bits. A four-way multiplexer, whose select lines are the class code itself, picks the instruction field that fills the low four address bits. Special words do not carry a usable field, so each of them gets a fixed sub-code.

The controlling state machine has three selects. The first one hands the address output over to an addressing-mode lookup that is computed elsewhere, for operand fetch and result save. The second one picks which of the two 6-bit operand fields goes out to the addressing-mode and register-address logic. The third one forces the register address to the program counter while the controller steps it. The 2-bit class code is also an output, and the controller uses it as the operand count.

Top module: `instr_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the held word to 0x0000. When `rst` is low, a rising edge with `ld_en` high captures `instr_in`. Without `ld_en` the held word and every output that depends only on it stay unchanged.
- R2: `op_count` classifies the held word as follows. A top nibble (bits 15..12) other than 1111 gives 01 (two-operand). 1111 with bits 11..9 = 110 gives 10 (one-operand). 1111 with bits 11..6 = 111111 and bit 5 = 0 gives 11 (zero-operand). Every other word gives 00 (special).
- R3: With `ins_op_sel` low, `rom_addr[6]` is 0 and `rom_addr[5:4]` equals `op_count`.
- R4: For a two-operand word, `rom_addr[3:0]` equals word bits 15..12.
- R5: For a one-operand word, `rom_addr[3:0]` equals word bits 9..6.
- R6: For a zero-operand word, `rom_addr[3:0]` equals word bits 3..0.
- R7: For a special word, `rom_addr[3:0]` is 0100 when bit 11 is 0 (branch). When bits 11..6 are 100000, 100001, 100010 or 100011, it is 0000, 0001, 0010 or 0011 respectively.
- R8: A special word that matches no pattern of R7 gives `rom_addr[3:0]` = 0000.
- R9: `operand_fld` is word bits 5..0 when `op_sel` is 0 and bits 11..6 when `op_sel` is 1.
- R10: With `ins_op_sel` high, `rom_addr` equals `mode_addr_in`, and `op_count` still reflects the held word.
- R11: `reg_addr_out` is 0x1F (program counter) when `reg_src_sel` is high, and equals `reg_addr_in` when it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Capture `instr_in` on the next rising edge |
| instr_in | input | 16 | Fetched instruction word |
| op_sel | input | 1 | Operand field choice: 0 = bits 5..0, 1 = bits 11..6 |
| ins_op_sel | input | 1 | Address source: 0 = group decode, 1 = `mode_addr_in` |
| mode_addr_in | input | 7 | Addressing-mode lookup address from outside |
| reg_src_sel | input | 1 | 1 forces the register address to the program counter |
| reg_addr_in | input | 5 | Register address from the register-address logic |
| rom_addr | output | 7 | Microcode entry lookup address |
| op_count | output | 2 | Instruction class / operand count |
| operand_fld | output | 6 | Selected operand field |
| reg_addr_out | output | 5 | Register address after the PC override |

## Verification
The assertions check the selector behaviour on every cycle: the program counter override and its pass-through, the external address takeover, the upper address bits following the class code, the class matching the top nibble of the held word, and the word holding while the load is idle. Which low-field value each class and special pattern produces, and the unmatched-special fallback, depend on specific bit patterns. Only the bench's table of representative words shows these, along with the operand-field choice and the reset value.

// File: rtl/iag_pkg.sv
package iag_pkg;
  localparam int IW_W   = 16;
  localparam int ADDR_W = 7;
  localparam int LOW_W  = 4;
  localparam int FLD_W  = 6;
  localparam int GRP_W  = 2;
  localparam int NGRP   = 1 << GRP_W;

  typedef enum logic [GRP_W-1:0] {
    GRP_SPECIAL = 2'b00,
    GRP_TWO     = 2'b01,
    GRP_ONE     = 2'b10,
    GRP_ZERO    = 2'b11
  } grp_e;

  localparam logic [LOW_W-1:0] SUB_BRANCH = 4'b0100;
  localparam logic [LOW_W-1:0] SUB_NONE   = 4'b0000;
endpackage

// File: rtl/iag_instr_reg.sv
module iag_instr_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (ld_en)
      q <= d;
  end
endmodule

// File: rtl/iag_decode.sv
module iag_decode
  import iag_pkg::*;
(
  input  logic [IW_W-1:0]  iw,
  input  logic             op_sel,
  output grp_e             grp,
  output logic [LOW_W-1:0] low,
  output logic [FLD_W-1:0] operand_fld
);
  logic             top_ones;
  logic             is_one, is_zero;
  logic [LOW_W-1:0] sub_code;
  logic [LOW_W-1:0] fld_src [NGRP];

  assign top_ones = &iw[15:12];
  assign is_one   = top_ones && (iw[11:9] == 3'b110);
  assign is_zero  = top_ones && (iw[11:6] == 6'b111111) && !iw[5];

  always_comb begin
    if (!top_ones)    grp = GRP_TWO;
    else if (is_one)  grp = GRP_ONE;
    else if (is_zero) grp = GRP_ZERO;
    else              grp = GRP_SPECIAL;
  end

  // Special sub-code: branch, or the four prefix-1000 specials, else none
  always_comb begin
    if (!iw[11])
      sub_code = SUB_BRANCH;
    else if (iw[10:8] == 3'b000)
      sub_code = {2'b00, iw[7:6]};
    else
      sub_code = SUB_NONE;
  end

  assign fld_src[GRP_SPECIAL] = sub_code;
  assign fld_src[GRP_TWO]     = iw[15:12];
  assign fld_src[GRP_ONE]     = iw[9:6];
  assign fld_src[GRP_ZERO]    = iw[3:0];

  // The class code doubles as the low-field multiplexer select
  assign low = fld_src[grp];

  assign operand_fld = op_sel ? iw[11:6] : iw[5:0];
endmodule

// File: rtl/iag_out_sel.sv
module iag_out_sel
  import iag_pkg::*;
#(
  parameter int               REG_W   = 5,
  parameter logic [REG_W-1:0] PC_ADDR = '1
) (
  input  grp_e              grp,
  input  logic [LOW_W-1:0]  low,
  input  logic              ins_op_sel,
  input  logic [ADDR_W-1:0] mode_addr_in,
  input  logic              reg_src_sel,
  input  logic [REG_W-1:0]  reg_addr_in,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [REG_W-1:0]  reg_addr_out
);
  localparam int PAD_W = ADDR_W - GRP_W - LOW_W;

  logic [ADDR_W-1:0] grp_addr;

  assign grp_addr     = {{PAD_W{1'b0}}, grp, low};
  assign rom_addr     = ins_op_sel ? mode_addr_in : grp_addr;
  assign reg_addr_out = reg_src_sel ? PC_ADDR : reg_addr_in;
endmodule

// File: rtl/instr_addr_gen.sv
module instr_addr_gen
  import iag_pkg::*;
#(
  parameter int               REG_W   = 5,
  parameter logic [REG_W-1:0] PC_ADDR = 5'h1F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [IW_W-1:0]   instr_in,
  input  logic              op_sel,
  input  logic              ins_op_sel,
  input  logic [ADDR_W-1:0] mode_addr_in,
  input  logic              reg_src_sel,
  input  logic [REG_W-1:0]  reg_addr_in,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [GRP_W-1:0]  op_count,
  output logic [FLD_W-1:0]  operand_fld,
  output logic [REG_W-1:0]  reg_addr_out
);
  logic [IW_W-1:0]  iw_q;
  grp_e             grp;
  logic [LOW_W-1:0] low;

  iag_instr_reg #(.W(IW_W)) u_ireg (
    .clk(clk), .rst(rst), .ld_en(ld_en), .d(instr_in), .q(iw_q)
  );

  iag_decode u_dec (
    .iw(iw_q), .op_sel(op_sel), .grp(grp), .low(low), .operand_fld(operand_fld)
  );

  iag_out_sel #(.REG_W(REG_W), .PC_ADDR(PC_ADDR)) u_sel (
    .grp(grp), .low(low), .ins_op_sel(ins_op_sel), .mode_addr_in(mode_addr_in),
    .reg_src_sel(reg_src_sel), .reg_addr_in(reg_addr_in),
    .rom_addr(rom_addr), .reg_addr_out(reg_addr_out)
  );

  assign op_count = grp;
endmodule

// File: rtl/instr_addr_gen_chk.sv
module instr_addr_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        ld_en,
  input logic [15:0] iw_q,
  input logic        ins_op_sel,
  input logic [6:0]  mode_addr_in,
  input logic        reg_src_sel,
  input logic [4:0]  reg_addr_in,
  input logic [6:0]  rom_addr,
  input logic [1:0]  op_count,
  input logic [4:0]  reg_addr_out
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ld_en |=> $stable(iw_q) && $stable(op_count)); // R1
  AST_TWO_OP_CLASS: assert property (@(posedge clk) disable iff (rst)
    (op_count == 2'b01) == !(&iw_q[15:12])); // R2
  AST_UPPER_BITS: assert property (@(posedge clk) disable iff (rst)
    !ins_op_sel |-> (rom_addr[6] == 1'b0) && (rom_addr[5:4] == op_count)); // R3
  AST_EXT_ADDR: assert property (@(posedge clk) disable iff (rst)
    ins_op_sel |-> rom_addr == mode_addr_in); // R10
  AST_PC_FORCE: assert property (@(posedge clk) disable iff (rst)
    reg_src_sel |-> reg_addr_out == 5'h1F); // R11
  AST_REG_PASS: assert property (@(posedge clk) disable iff (rst)
    !reg_src_sel |-> reg_addr_out == reg_addr_in); // R11
endmodule

bind instr_addr_gen instr_addr_gen_chk u_chk (
  .clk(clk), .rst(rst), .ld_en(ld_en), .iw_q(iw_q), .ins_op_sel(ins_op_sel),
  .mode_addr_in(mode_addr_in), .reg_src_sel(reg_src_sel), .reg_addr_in(reg_addr_in),
  .rom_addr(rom_addr), .op_count(op_count), .reg_addr_out(reg_addr_out)
);

// File: tb/instr_addr_gen_test.sv
`timescale 1ns/1ps
module instr_addr_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0;
  logic [15:0] instr_in = '0;
  logic       op_sel = 1'b0;
  logic       ins_op_sel = 1'b0;
  logic [6:0] mode_addr_in = '0;
  logic       reg_src_sel = 1'b0;
  logic [4:0] reg_addr_in = '0;
  logic [6:0] rom_addr;
  logic [1:0] op_count;
  logic [5:0] operand_fld;
  logic [4:0] reg_addr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  instr_addr_gen uut (
    .clk(clk), .rst(rst), .ld_en(ld_en), .instr_in(instr_in), .op_sel(op_sel),
    .ins_op_sel(ins_op_sel), .mode_addr_in(mode_addr_in), .reg_src_sel(reg_src_sel),
    .reg_addr_in(reg_addr_in), .rom_addr(rom_addr), .op_count(op_count),
    .operand_fld(operand_fld), .reg_addr_out(reg_addr_out)
  );

  typedef struct packed {
    logic [15:0] word;
    logic [6:0]  addr;
    logic [1:0]  cnt;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 7'h10, 2'b01},  // R2 R3 R4 two-operand
    '{16'hA5C3, 7'h1A, 2'b01},  // R4
    '{16'hE123, 7'h1E, 2'b01},  // R4 highest two-operand nibble
    '{16'hFD60, 7'h25, 2'b10},  // R5 one-operand
    '{16'hFDFF, 7'h27, 2'b10},  // R5
    '{16'hFC00, 7'h20, 2'b10},  // R5
    '{16'hFFC5, 7'h35, 2'b11},  // R6 zero-operand
    '{16'hFFCF, 7'h3F, 2'b11},  // R6
    '{16'hF000, 7'h04, 2'b00},  // R7 branch
    '{16'hF7FF, 7'h04, 2'b00},  // R7 branch
    '{16'hF82A, 7'h00, 2'b00},  // R7 immediate-mode
    '{16'hF855, 7'h01, 2'b00},  // R7 software interrupt
    '{16'hF885, 7'h02, 2'b00},  // R7 jump
    '{16'hF8C7, 7'h03, 2'b00},  // R7 jump to subroutine
    '{16'hF900, 7'h00, 2'b00},  // R8 unmatched special
    '{16'hFFE0, 7'h00, 2'b00}   // R8 111111 with bit 5 set
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_word(input logic [15:0] w);
    @(negedge clk);
    instr_in = w;
    ld_en = 1'b1;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state: word 0000 decodes as two-operand nibble 0
    check("R1 reset addr", 16'(rom_addr), 16'h10);
    check("R1 reset count", 16'(op_count), 16'h1);
    check("R1 reset field", 16'(operand_fld), 16'h0);

    for (int i = 0; i < NV; i++) begin
      load_word(VECS[i].word);
      check("R2 count", 16'(op_count), 16'(VECS[i].cnt));
      check("R3-8 addr", 16'(rom_addr), 16'(VECS[i].addr));
    end

    // R1 hold without load
    load_word(16'hFD60);
    @(negedge clk);
    instr_in = 16'h1234;
    @(negedge clk);
    @(negedge clk);
    check("R1 hold addr", 16'(rom_addr), 16'h25);

    // R9 operand field select on A5C3
    load_word(16'hA5C3);
    op_sel = 1'b0;
    #1 check("R9 low field", 16'(operand_fld), 16'h03);
    op_sel = 1'b1;
    #1 check("R9 high field", 16'(operand_fld), 16'h17);
    op_sel = 1'b0;

    // R10 external address takeover
    mode_addr_in = 7'h5B;
    ins_op_sel = 1'b1;
    #1 check("R10 ext addr", 16'(rom_addr), 16'h5B);
    check("R10 count kept", 16'(op_count), 16'h1);
    mode_addr_in = 7'h44;
    #1 check("R10 ext addr 2", 16'(rom_addr), 16'h44);
    ins_op_sel = 1'b0;
    #1 check("R10 back to decode", 16'(rom_addr), 16'h1A);

    // R11 register address override
    reg_addr_in = 5'h0A;
    reg_src_sel = 1'b0;
    #1 check("R11 pass", 16'(reg_addr_out), 16'h0A);
    reg_src_sel = 1'b1;
    #1 check("R11 force PC", 16'(reg_addr_out), 16'h1F);
    reg_src_sel = 1'b0;

    // R1 reset wins over load
    @(negedge clk);
    instr_in = 16'hFFC5;
    ld_en = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ld_en = 1'b0;
    check("R1 reset priority", 16'(rom_addr), 16'h10);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule